// File: doc/BRIEF.md
# Packetized NAND Data Port Sequencer

This block sits between a host register interface and the byte-wide data path of a NAND flash channel. It moves page, parameter, ID and feature data one packet at a time. The host writes a configuration word that holds the packet size and the packet count. It then writes a one-hot program word, which picks the operation. For reads, the block gathers one packet of bytes from the flash-side input stream into a staging buffer. It then raises a read-ready pulse, and the host pulls the packet out as 32-bit words through a single data-port register. For writes, the block raises a write-ready pulse, takes one packet of words from the host, and sends them out as bytes on the flash-side output stream. After the last packet of the programmed count, the block raises a completion pulse.

Operations that carry no data (erase, status, reset) only announce themselves on the operation strobe. They finish when the flash side returns `op_done`, and they raise nothing but the completion pulse. Both flash-side streams use valid/ready handshakes. A byte moves on a rising clock edge where valid and ready are both high. While `tx_valid` is high and `tx_ready` is low, `tx_data` must stay the same. The block raises `rx_ready` only while it is filling a read packet, so an idle or draining buffer holds the source back.

Top module: `nand_pkt_seq`

## Requirements
- R1: The configuration word (register address 0) holds the packet size in bytes in bits 11:0 and the packet count in bits 12 upward (12 bits by default). Reading address 0 returns the whole word as last written. Read data appears on `reg_rdata` in the cycle after `reg_re`.
- R2: Writing the program register (address 1) with exactly one of bits 0 (page read), 2 (erase), 3 (status), 4 (page program), 6 (read ID), 7 (read parameter page), 8 (reset), 9 (get feature) or 10 (set feature) starts that operation. `op_start` pulses once, and `op_code` carries the index of that bit. A program word with zero bits, several bits or any other bit set is ignored.
- R3: A read operation (bits 0, 6, 7, 9) takes exactly packet-size bytes from the input stream for each packet and then pulses `evt_rd_rdy` once. `rx_ready` stays low until the host has emptied that packet.
- R4: Each read of the data port (address 2) during a ready read packet returns the next word, packed little-endian (the earliest byte in bits 7:0). There are packet-size/4 words per packet.
- R5: A write operation (bits 4, 10) pulses `evt_wr_rdy` once per packet. It accepts packet-size/4 words on the data port, then drives exactly those bytes on the output stream in order, lowest byte of each word first.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values into the next cycle.
- R7: `evt_done` pulses exactly once, only after the last packet of the programmed count has been moved. At most one event pulse is high in any cycle, and `busy` falls in the cycle of `evt_done`.
- R8: Erase, status and reset raise neither ready pulse. They stay busy until `op_done` is sampled high, and then pulse `evt_done`.
- R9: A program write is ignored while busy. A start is also ignored when the configuration holds a size of zero, a size not a multiple of 4, a size above the buffer capacity (1024 bytes by default), or a count of zero.
- R10: A data-port read when no read word is available returns zero and sets the sticky `underflow` output. The flag clears only when the next operation is accepted.
- R11: A data-port write outside the word-collecting phase of a write packet does not change the buffer or the bytes sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 configuration, 1 program, 2 data port |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after `reg_re` |
| evt_rd_rdy | output | 1 | One-cycle pulse: a read packet is ready in the buffer |
| evt_wr_rdy | output | 1 | One-cycle pulse: the buffer can take a write packet |
| evt_done | output | 1 | One-cycle pulse: the operation has completed |
| busy | output | 1 | An operation is in progress |
| underflow | output | 1 | Sticky: the data port was read with no word available |
| op_start | output | 1 | One-cycle pulse announcing an accepted operation |
| op_code | output | 4 | Program bit index of the current operation |
| op_done | input | 1 | Flash side reports that a no-data operation has finished |
| rx_valid | input | 1 | Input stream byte valid |
| rx_ready | output | 1 | Block accepts an input byte |
| rx_data | input | 8 | Input stream byte |
| tx_valid | output | 1 | Output stream byte valid |
| tx_ready | input | 1 | Flash side accepts an output byte |
| tx_data | output | 8 | Output stream byte |

## Verification
Reads and writes are tried with the short packet sizes (4 and 8 bytes) and with the page sizes (512 and 1024 bytes). This tells apart single-packet handling from multi-packet handling with counts of one to three, and it exercises the word-index wrap at a full buffer. Input bytes arrive with random gaps, and output bytes meet random back-pressure. This separates the handshake from the packing order, because a dropped or repeated byte shows up as a shifted word. Directed cases cover the following:
- a program write while busy;
- each kind of illegal configuration and program word;
- a data-port write during the output phase;
- an empty data-port read;
- the no-data operations with a delayed `op_done`.

// File: rtl/nand_pkt_pkg.sv
package nand_pkt_pkg;

  // Size field occupies the low bits, count starts at this position
  localparam int unsigned SIZE_W  = 12;
  localparam int unsigned CNT_LSB = 12;

  // Program word: only these bit positions name an operation
  localparam int unsigned PROG_W = 11;
  localparam logic [PROG_W-1:0] PROG_KNOWN = 11'h7DD;

  localparam logic [1:0] A_CFG  = 2'd0;
  localparam logic [1:0] A_PROG = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  typedef enum logic [1:0] {
    XFER_NONE,
    XFER_IN,
    XFER_OUT
  } xfer_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FILL_IN,
    S_HOST_RD,
    S_HOST_WR,
    S_DRAIN_OUT,
    S_WAIT_OP
  } seq_state_e;

  // Direction of the data moved by each operation code
  function automatic xfer_e op_class(input logic [3:0] code);
    case (code)
      4'd0, 4'd6, 4'd7, 4'd9: op_class = XFER_IN;
      4'd4, 4'd10:            op_class = XFER_OUT;
      default:                op_class = XFER_NONE;
    endcase
  endfunction

endpackage

// File: rtl/nps_prog_decode.sv
module nps_prog_decode
  import nand_pkt_pkg::*;
(
  input  logic [31:0] prog_word,
  output logic        legal,
  output logic [3:0]  code,
  output xfer_e       dir
);

  always_comb begin
    code = '0;
    for (int i = 0; i < int'(PROG_W); i++) begin
      if (prog_word[i]) code = 4'(i);
    end
    legal = $onehot(prog_word) && ((prog_word[PROG_W-1:0] & PROG_KNOWN) != '0);
    dir   = op_class(code);
  end

endmodule

// File: rtl/nps_stage_buf.sv
module nps_stage_buf #(
  parameter int unsigned WORDS   = 256,
  parameter int unsigned WADDR_W = 8
) (
  input  logic               clk,
  input  logic               byte_we,
  input  logic [WADDR_W+1:0] byte_addr,
  input  logic [7:0]         byte_in,
  input  logic               word_we,
  input  logic [WADDR_W-1:0] word_addr,
  input  logic [31:0]        word_in,
  output logic [31:0]        word_out,
  output logic [7:0]         byte_out
);

  logic [7:0] lane_byte [4];

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] mem [WORDS];

    always_ff @(posedge clk) begin
      if (word_we) begin
        mem[word_addr] <= word_in[8*l +: 8];
      end else if (byte_we && (byte_addr[1:0] == 2'(l))) begin
        mem[byte_addr[WADDR_W+1:2]] <= byte_in;
      end
    end

    assign word_out[8*l +: 8] = mem[word_addr];
    assign lane_byte[l]       = mem[byte_addr[WADDR_W+1:2]];
  end

  assign byte_out = lane_byte[byte_addr[1:0]];

endmodule

// File: rtl/nps_ctrl.sv
module nps_ctrl
  import nand_pkt_pkg::*;
#(
  parameter int unsigned MAX_PKT_BYTES = 1024,
  parameter int unsigned CNT_W         = 12,
  parameter int unsigned ADDR_W        = 10,
  parameter int unsigned SZ_W          = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic              prog_legal,
  input  logic [3:0]        prog_code,
  input  xfer_e             prog_dir,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              op_done,
  input  logic              rx_valid,
  input  logic              tx_ready,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic              buf_byte_we,
  output logic              buf_word_we,
  output logic [ADDR_W-1:0] pos,
  output logic              word_avail,
  output logic              evt_rd_rdy,
  output logic              evt_wr_rdy,
  output logic              evt_done,
  output logic              busy,
  output logic              underflow,
  output logic              op_start,
  output logic [3:0]        op_code
);

  seq_state_e        state;
  logic [SZ_W-1:0]   size_q;
  logic [CNT_W-1:0]  left_q;
  logic [SZ_W-1:0]   pos_p1, pos_p4;
  logic              cfg_ok, start, last_pkt;

  assign cfg_ok = (cfg_size != '0) && (cfg_size[1:0] == 2'b00) &&
                  (cfg_size <= SIZE_W'(MAX_PKT_BYTES)) && (cfg_cnt != '0);
  assign start  = prog_we && prog_legal && cfg_ok && (state == S_IDLE);

  assign busy        = (state != S_IDLE);
  assign rx_ready    = (state == S_FILL_IN);
  assign tx_valid    = (state == S_DRAIN_OUT);
  assign word_avail  = (state == S_HOST_RD);
  assign buf_byte_we = rx_ready && rx_valid;
  assign buf_word_we = data_wr && (state == S_HOST_WR);

  assign pos_p1   = SZ_W'(pos) + SZ_W'(1);
  assign pos_p4   = SZ_W'(pos) + SZ_W'(4);
  assign last_pkt = (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      size_q     <= '0;
      left_q     <= '0;
      pos        <= '0;
      evt_rd_rdy <= 1'b0;
      evt_wr_rdy <= 1'b0;
      evt_done   <= 1'b0;
      underflow  <= 1'b0;
      op_start   <= 1'b0;
      op_code    <= '0;
    end else begin
      evt_rd_rdy <= 1'b0;
      evt_wr_rdy <= 1'b0;
      evt_done   <= 1'b0;
      op_start   <= 1'b0;
      if (data_rd && (state != S_HOST_RD)) underflow <= 1'b1;

      case (state)
        S_IDLE: begin
          if (start) begin
            op_code   <= prog_code;
            op_start  <= 1'b1;
            size_q    <= SZ_W'(cfg_size);
            left_q    <= cfg_cnt;
            pos       <= '0;
            underflow <= 1'b0;
            case (prog_dir)
              XFER_IN:  state <= S_FILL_IN;
              XFER_OUT: begin
                state      <= S_HOST_WR;
                evt_wr_rdy <= 1'b1;
              end
              default:  state <= S_WAIT_OP;
            endcase
          end
        end
        S_FILL_IN: begin
          if (rx_valid) begin
            pos <= pos_p1[ADDR_W-1:0];
            if (pos_p1 == size_q) begin
              pos        <= '0;
              state      <= S_HOST_RD;
              evt_rd_rdy <= 1'b1;
            end
          end
        end
        S_HOST_RD: begin
          if (data_rd) begin
            pos <= pos_p4[ADDR_W-1:0];
            if (pos_p4 == size_q) begin
              pos <= '0;
              if (last_pkt) begin
                state    <= S_IDLE;
                evt_done <= 1'b1;
              end else begin
                left_q <= left_q - CNT_W'(1);
                state  <= S_FILL_IN;
              end
            end
          end
        end
        S_HOST_WR: begin
          if (data_wr) begin
            pos <= pos_p4[ADDR_W-1:0];
            if (pos_p4 == size_q) begin
              pos   <= '0;
              state <= S_DRAIN_OUT;
            end
          end
        end
        S_DRAIN_OUT: begin
          if (tx_ready) begin
            pos <= pos_p1[ADDR_W-1:0];
            if (pos_p1 == size_q) begin
              pos <= '0;
              if (last_pkt) begin
                state    <= S_IDLE;
                evt_done <= 1'b1;
              end else begin
                left_q     <= left_q - CNT_W'(1);
                state      <= S_HOST_WR;
                evt_wr_rdy <= 1'b1;
              end
            end
          end
        end
        S_WAIT_OP: begin
          if (op_done) begin
            state    <= S_IDLE;
            evt_done <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_rd_rdy, evt_wr_rdy, evt_done}));

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> evt_done);

  // R3
  rd_rdy_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_rdy |-> $past(rx_valid && rx_ready));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && prog_we) |=> !op_start);

  // R10
  uflow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(underflow) |-> op_start);

  // R8
  op_done_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done && $past(state == S_WAIT_OP)) |-> $past(op_done));

endmodule

// File: rtl/nand_pkt_seq.sv
module nand_pkt_seq
  import nand_pkt_pkg::*;
#(
  parameter int unsigned MAX_PKT_BYTES = 1024,
  parameter int unsigned CNT_W         = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        evt_rd_rdy,
  output logic        evt_wr_rdy,
  output logic        evt_done,
  output logic        busy,
  output logic        underflow,
  output logic        op_start,
  output logic [3:0]  op_code,
  input  logic        op_done,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data
);

  localparam int unsigned WORDS   = MAX_PKT_BYTES / 4;
  localparam int unsigned WADDR_W = $clog2(WORDS);
  localparam int unsigned ADDR_W  = WADDR_W + 2;
  localparam int unsigned SZ_W    = $clog2(MAX_PKT_BYTES + 1);

  logic [31:0]       cfg_q;
  logic              prog_we, data_wr, data_rd;
  logic              prog_legal;
  logic [3:0]        prog_code;
  xfer_e             prog_dir;
  logic              byte_we, word_we, word_avail;
  logic [ADDR_W-1:0] pos;
  logic [31:0]       word_out;

  assign prog_we = reg_we && (reg_addr == A_PROG);
  assign data_wr = reg_we && (reg_addr == A_DATA);
  assign data_rd = reg_re && (reg_addr == A_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_we && (reg_addr == A_CFG)) cfg_q <= reg_wdata;
      if (reg_re) begin
        case (reg_addr)
          A_CFG:   reg_rdata <= cfg_q;
          A_DATA:  reg_rdata <= word_avail ? word_out : 32'd0;
          default: reg_rdata <= 32'd0;
        endcase
      end
    end
  end

  nps_prog_decode u_dec (
    .prog_word (reg_wdata),
    .legal     (prog_legal),
    .code      (prog_code),
    .dir       (prog_dir)
  );

  nps_ctrl #(
    .MAX_PKT_BYTES (MAX_PKT_BYTES),
    .CNT_W         (CNT_W),
    .ADDR_W        (ADDR_W),
    .SZ_W          (SZ_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_we     (prog_we),
    .prog_legal  (prog_legal),
    .prog_code   (prog_code),
    .prog_dir    (prog_dir),
    .cfg_size    (cfg_q[SIZE_W-1:0]),
    .cfg_cnt     (cfg_q[CNT_LSB +: CNT_W]),
    .data_rd     (data_rd),
    .data_wr     (data_wr),
    .op_done     (op_done),
    .rx_valid    (rx_valid),
    .tx_ready    (tx_ready),
    .rx_ready    (rx_ready),
    .tx_valid    (tx_valid),
    .buf_byte_we (byte_we),
    .buf_word_we (word_we),
    .pos         (pos),
    .word_avail  (word_avail),
    .evt_rd_rdy  (evt_rd_rdy),
    .evt_wr_rdy  (evt_wr_rdy),
    .evt_done    (evt_done),
    .busy        (busy),
    .underflow   (underflow),
    .op_start    (op_start),
    .op_code     (op_code)
  );

  nps_stage_buf #(
    .WORDS   (WORDS),
    .WADDR_W (WADDR_W)
  ) u_buf (
    .clk       (clk),
    .byte_we   (byte_we),
    .byte_addr (pos),
    .byte_in   (rx_data),
    .word_we   (word_we),
    .word_addr (pos[ADDR_W-1:2]),
    .word_in   (reg_wdata),
    .word_out  (word_out),
    .byte_out  (tx_data)
  );

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: tb/test_nand_pkt_seq.sv
`timescale 1ns/1ps
module test_nand_pkt_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        evt_rd_rdy, evt_wr_rdy, evt_done, busy, underflow, op_start;
  logic [3:0]  op_code;
  logic        op_done = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;

  always #2.5 clk = ~clk;

  nand_pkt_seq i_nand_pkt_seq (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_rd_rdy(evt_rd_rdy),
    .evt_wr_rdy(evt_wr_rdy), .evt_done(evt_done), .busy(busy), .underflow(underflow),
    .op_start(op_start), .op_code(op_code), .op_done(op_done), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data)
  );

  int n_chk = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0, n_done = 0, n_ops = 0;
  logic [3:0] seen_code = '0;
  logic [7:0] exp_b [1024];

  always @(negedge clk) begin
    if (evt_rd_rdy) n_rd++;
    if (evt_wr_rdy) n_wr++;
    if (evt_done)   n_done++;
    if (op_start) begin
      n_ops++;
      seen_code = op_code;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    tick();
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    tick();
    reg_re = 1'b1; reg_addr = a;
    tick();
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] cfg_word(input int size, input int cnt);
    return (32'(cnt) << 12) | 32'(size);
  endfunction

  function automatic logic [31:0] exp_word(input int w);
    return {exp_b[4*w+3], exp_b[4*w+2], exp_b[4*w+1], exp_b[4*w]};
  endfunction

  // Read operation: feed packets on the input stream, drain words from the port
  task automatic run_read(input int size, input int cnt, input int bitn,
                          input bit gaps, input bit poke);
    int r0, d0, o0, w0;
    logic [31:0] d;
    reg_wr(2'd0, cfg_word(size, cnt));
    r0 = n_rd; d0 = n_done; o0 = n_ops; w0 = n_wr;
    reg_wr(2'd1, 32'd1 << bitn);
    check(n_ops == o0 + 1 && seen_code == 4'(bitn), "R2 read start code",
          32'(seen_code), 32'(bitn));
    for (int p = 0; p < cnt; p++) begin
      for (int i = 0; i < size; i++) begin
        if (poke && p == 0 && i == 3) begin
          rx_valid = 1'b0;
          reg_wr(2'd1, 32'd1 << 4);
          check(n_ops == o0 + 1 && busy, "R9 program while busy ignored",
                32'(n_ops), 32'(o0 + 1));
        end
        exp_b[i] = 8'($urandom);
        if (gaps && ($urandom % 4 == 0)) begin
          rx_valid = 1'b0;
          tick();
        end
        rx_valid = 1'b1; rx_data = exp_b[i];
        while (!rx_ready) tick();
        tick();
      end
      rx_valid = 1'b1; rx_data = 8'hEE;
      check(n_rd == r0 + p + 1, "R3 one read-ready per packet", 32'(n_rd), 32'(r0 + p + 1));
      tick();
      check(!rx_ready, "R3 input held off while draining", 32'(rx_ready), 32'd0);
      tick();
      rx_valid = 1'b0;
      for (int w = 0; w < size / 4; w++) begin
        reg_rd(2'd2, d);
        check(d == exp_word(w), "R4 packed read word", d, exp_word(w));
        if (w < size / 4 - 1 || p < cnt - 1)
          check(n_done == d0, "R7 no early completion", 32'(n_done), 32'(d0));
      end
    end
    check(n_done == d0 + 1 && !busy, "R7 single completion after last packet",
          32'(n_done), 32'(d0 + 1));
    check(n_wr == w0, "R3 no write-ready in a read", 32'(n_wr), 32'(w0));
  endtask

  // Write operation: supply words per packet, collect bytes with back-pressure
  task automatic run_write(input int size, input int cnt, input int bitn,
                           input bit bp, input bit inject);
    int w0, d0, o0, idx;
    bit stalled, inj_done;
    logic [31:0] wd;
    logic [7:0] held;
    reg_wr(2'd0, cfg_word(size, cnt));
    w0 = n_wr; d0 = n_done; o0 = n_ops;
    reg_wr(2'd1, 32'd1 << bitn);
    check(n_ops == o0 + 1 && seen_code == 4'(bitn), "R2 write start code",
          32'(seen_code), 32'(bitn));
    inj_done = 1'b0;
    for (int p = 0; p < cnt; p++) begin
      check(n_wr == w0 + p + 1, "R5 one write-ready per packet", 32'(n_wr), 32'(w0 + p + 1));
      for (int w = 0; w < size / 4; w++) begin
        wd = $urandom;
        {exp_b[4*w+3], exp_b[4*w+2], exp_b[4*w+1], exp_b[4*w]} = wd;
        reg_wr(2'd2, wd);
      end
      idx = 0; stalled = 1'b0; held = '0;
      while (idx < size) begin
        tx_ready = bp ? 1'($urandom) : 1'b1;
        if (stalled)
          check(tx_valid && tx_data == held, "R6 data held under back-pressure",
                32'(tx_data), 32'(held));
        check(tx_valid && tx_data == exp_b[idx],
              (inj_done ? "R11 stray port write ignored" : "R5 output byte order"),
              32'(tx_data), 32'(exp_b[idx]));
        stalled = tx_valid && !tx_ready;
        held = tx_data;
        if (tx_ready) idx++;
        if (inject && p == 0 && idx == 2 && !inj_done) begin
          reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'hDEAD_BEEF;
          inj_done = 1'b1;
        end
        tick();
        reg_we = 1'b0;
      end
      tx_ready = 1'b0;
    end
    check(n_done == d0 + 1 && !busy, "R7 completion after last write packet",
          32'(n_done), 32'(d0 + 1));
  endtask

  task automatic run_nodata(input int bitn, input int delay);
    int r0, w0, d0;
    reg_wr(2'd0, cfg_word(4, 1));
    r0 = n_rd; w0 = n_wr; d0 = n_done;
    reg_wr(2'd1, 32'd1 << bitn);
    check(busy && seen_code == 4'(bitn), "R2 no-data op code", 32'(seen_code), 32'(bitn));
    for (int i = 0; i < delay; i++) tick();
    check(busy && n_done == d0, "R8 waits for op_done", 32'(n_done), 32'(d0));
    op_done = 1'b1;
    tick();
    op_done = 1'b0;
    check(n_done == d0 + 1 && !busy, "R8 completion after op_done", 32'(n_done), 32'(d0 + 1));
    check(n_rd == r0 && n_wr == w0, "R8 no ready events", 32'(n_rd + n_wr), 32'(r0 + w0));
  endtask

  task automatic try_illegal(input logic [31:0] cfg, input logic [31:0] prog,
                             input string what);
    int o0;
    reg_wr(2'd0, cfg);
    o0 = n_ops;
    reg_wr(2'd1, prog);
    tick();
    check(!busy && n_ops == o0, what, 32'(busy), 32'd0);
  endtask

  initial begin
    #750000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED));
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    check(!busy && !underflow && !rx_ready && !tx_valid && !evt_done && !evt_rd_rdy && !evt_wr_rdy,
          "R7 reset state idle", {busy, underflow, rx_ready, tx_valid}, 32'd0);

    // R1 configuration readback
    reg_wr(2'd0, 32'h00A3_5208);
    reg_rd(2'd0, d);
    check(d == 32'h00A3_5208, "R1 config readback", d, 32'h00A3_5208);

    // R10 empty read
    reg_rd(2'd2, d);
    check(d == 32'd0 && underflow, "R10 empty read returns zero", d, 32'd0);
    tick();
    check(underflow, "R10 underflow sticky", 32'(underflow), 32'd1);
    run_nodata(3, 5);
    check(!underflow, "R10 underflow cleared by accepted start", 32'(underflow), 32'd0);

    // Directed short and page transfers
    run_read(8, 1, 6, 1'b0, 1'b1);
    run_read(4, 1, 9, 1'b1, 1'b0);
    run_write(4, 1, 10, 1'b0, 1'b0);
    run_write(8, 2, 10, 1'b1, 1'b1);
    run_read(1024, 2, 0, 1'b1, 1'b0);
    run_write(512, 2, 4, 1'b1, 1'b1);
    run_read(256, 3, 7, 1'b0, 1'b0);
    run_nodata(2, 3);
    run_nodata(8, 0);

    // R9 illegal configurations and R2 illegal program words
    try_illegal(cfg_word(6, 1), 32'd1, "R9 size not multiple of 4 ignored");
    try_illegal(cfg_word(0, 1), 32'd1, "R9 zero size ignored");
    try_illegal(cfg_word(2048, 1), 32'd1, "R9 oversize ignored");
    try_illegal(cfg_word(8, 0), 32'd1, "R9 zero count ignored");
    try_illegal(cfg_word(8, 1), 32'h11, "R2 two program bits ignored");
    try_illegal(cfg_word(8, 1), 32'h2, "R2 unknown program bit ignored");
    try_illegal(cfg_word(8, 1), 32'h800, "R2 high program bit ignored");
    try_illegal(cfg_word(8, 1), 32'h0, "R2 empty program word ignored");

    // Constrained random mix
    for (int it = 0; it < 8; it++) begin
      int sizes [6] = '{4, 8, 16, 64, 512, 1024};
      int rbits [4] = '{0, 6, 7, 9};
      int wbits [2] = '{4, 10};
      int sz, cn;
      sz = sizes[$urandom % 6];
      cn = 1 + int'($urandom % 3);
      if ($urandom % 2 == 0)
        run_read(sz, cn, rbits[$urandom % 4], 1'($urandom), 1'b0);
      else
        run_write(sz, cn, wbits[$urandom % 2], 1'($urandom), 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule